// File: doc/BRIEF.md
# PHY Configuration Packet Transmit Formatter

This block sits on the transmit side of a serial-bus link layer. It takes quadlets that a host writes into the asynchronous transmit path through an address-decoded write port, and it hands quadlets to the PHY side over a valid/ready port. Most quadlets pass straight through. The exception is a two-quadlet PHY configuration packet.

A configuration packet begins with a first-quadlet write whose low half-word is the fixed marker 00E0h. The block holds that quadlet and clears the marker nibble, so the low half-word leaves as 0000h. It then waits for the second quadlet on its own register offset. The second quadlet must be the bitwise complement of the cleaned first quadlet. If it is, both quadlets go out in order, followed by a done pulse. If it is not, or if the writes arrive in the wrong order, the block drops the packet and raises a sticky error flag.

Top module: `phycfg_tx_fmt`

## Requirements
- R1: While `rst` is high and on the cycle after it, `out_valid`, `done` and `err` are 0.
- R2: Take a write to offset 80h whose low 16 bits equal 00E0h, followed by a write to offset 8Ch holding {~first[31:16], FFFFh}.
  - The block first sends {first[31:16], 0000h), then the second quadlet unchanged.
  - The root-ID field [29:24], the R flag [23], the T flag [22] and the gap-count field [21:16] are carried through untouched.
- R3: Output holding and ordering.
  - After the first quadlet of a pair is written, nothing is presented on the output.
  - A presented quadlet stays valid with stable data until `out_ready` is seen high at a clock edge.
  - The second quadlet is presented only after the first has been accepted.
- R4: If the 8Ch write does not equal the bitwise NOT of the cleaned first quadlet, `err` is set and neither quadlet is sent.
- R5: A write to 8Ch when no first quadlet is held sets `err` and sends nothing.
- R6: A write to 80h while a first quadlet is held sets `err`, discards both quadlets and returns to idle. A later 8Ch write is then a sequence error too.
- R7: A write to 80h whose low half-word is not 00E0h is sent unchanged as one quadlet, and it produces no `done` pulse.
- R8: `done` is high for exactly one cycle, the cycle after the edge at which the second configuration quadlet is accepted.
- R9: Once set, `err` stays 1 until reset, even while later packets are sent correctly.
- R10: The following writes change neither the output nor `err`:
  - writes to any offset other than 80h and 8Ch;
  - any write made while a quadlet is waiting on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W (8) | Register offset of the write |
| wr_data | input | DATA_W (32) | Quadlet being written |
| out_valid | output | 1 | Quadlet presented to PHY side |
| out_data | output | DATA_W (32) | Quadlet to PHY side |
| out_ready | input | 1 | PHY side accepts the quadlet |
| done | output | 1 | One-cycle pulse after a configuration packet completes |
| err | output | 1 | Sticky pairing or sequence error |

## Verification
The bench builds the block with its default parameters: 32-bit quadlets, 8-bit offsets, first and second offsets 80h and 8Ch, and marker 00E0h. With these defaults the real field layout is in play. Marker detection, the nibble clearing and the complement check therefore run on genuine root-ID, flag and gap-count bit patterns, including all-zero and all-one upper halves and a near-miss marker of 00E1h. Output stalls of zero to two cycles expose the hold and ordering rules, and writes issued during a stall test R10.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GOT_FIRST,
    ST_SEND_Q1,
    ST_SEND_Q2,
    ST_SEND_RAW
  } fmt_state_t;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_FIRST,
    WR_SECOND
  } wr_kind_t;
endpackage

// File: rtl/phycfg_decode.sv
module phycfg_decode #(
  parameter int ADDR_W = 8,
  parameter int MARK_W = 16,
  parameter logic [ADDR_W-1:0] FIRST_OFS = 8'h80,
  parameter logic [ADDR_W-1:0] SECOND_OFS = 8'h8C,
  parameter logic [MARK_W-1:0] MARKER = 16'h00E0
) (
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [MARK_W-1:0]     wr_low,
  output phycfg_pkg::wr_kind_t  wr_kind,
  output logic                  is_marker
);
  import phycfg_pkg::*;

  always_comb begin
    wr_kind = WR_NONE;
    if (wr_en) begin
      if (wr_addr == FIRST_OFS)       wr_kind = WR_FIRST;
      else if (wr_addr == SECOND_OFS) wr_kind = WR_SECOND;
    end
  end

  assign is_marker = (wr_low == MARKER);
endmodule

// File: rtl/phycfg_pair_chk.sv
module phycfg_pair_chk #(
  parameter int DATA_W = 32,
  parameter int MARK_W = 16,
  parameter logic [MARK_W-1:0] MARKER = 16'h00E0,
  parameter int NIB_POS = 4
) (
  input  logic [DATA_W-1:0] raw_first,
  input  logic [DATA_W-1:0] held_first,
  input  logic [DATA_W-1:0] second,
  output logic [DATA_W-1:0] clean_first,
  output logic              pair_ok
);
  localparam logic [MARK_W-1:0] NIB_MASK  = MARK_W'(4'hF) << NIB_POS;
  localparam logic [MARK_W-1:0] SENT_MARK = MARKER & ~NIB_MASK;

  assign clean_first = {raw_first[DATA_W-1:MARK_W], SENT_MARK};
  assign pair_ok     = (second == ~held_first);
endmodule

// File: rtl/phycfg_out_reg.sv
module phycfg_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/phycfg_tx_fmt.sv
module phycfg_tx_fmt #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int MARK_W = 16,
  parameter logic [ADDR_W-1:0] FIRST_OFS = 8'h80,
  parameter logic [ADDR_W-1:0] SECOND_OFS = 8'h8C,
  parameter logic [MARK_W-1:0] MARKER = 16'h00E0,
  parameter int NIB_POS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              done,
  output logic              err
);
  import phycfg_pkg::*;

  fmt_state_t        st;
  wr_kind_t          wr_kind;
  logic              is_marker;
  logic [DATA_W-1:0] held_q1, held_q2, clean_first;
  logic              pair_ok, accept, load;
  logic [DATA_W-1:0] load_data;

  phycfg_decode #(
    .ADDR_W(ADDR_W), .MARK_W(MARK_W),
    .FIRST_OFS(FIRST_OFS), .SECOND_OFS(SECOND_OFS), .MARKER(MARKER)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_low(wr_data[MARK_W-1:0]),
    .wr_kind(wr_kind), .is_marker(is_marker)
  );

  phycfg_pair_chk #(
    .DATA_W(DATA_W), .MARK_W(MARK_W), .MARKER(MARKER), .NIB_POS(NIB_POS)
  ) u_pair (
    .raw_first(wr_data), .held_first(held_q1), .second(wr_data),
    .clean_first(clean_first), .pair_ok(pair_ok)
  );

  phycfg_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .load(load), .load_data(load_data),
    .ready(out_ready), .valid(out_valid), .data(out_data)
  );

  assign accept = out_valid && out_ready;

  always_comb begin
    load      = 1'b0;
    load_data = wr_data;
    case (st)
      ST_IDLE: load = (wr_kind == WR_FIRST) && !is_marker;
      ST_GOT_FIRST: begin
        load      = (wr_kind == WR_SECOND) && pair_ok;
        load_data = held_q1;
      end
      ST_SEND_Q1: begin
        load      = accept;
        load_data = held_q2;
      end
      default: load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      held_q1 <= '0;
      held_q2 <= '0;
      err     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (wr_kind == WR_FIRST) begin
            if (is_marker) begin
              held_q1 <= clean_first;
              st      <= ST_GOT_FIRST;
            end else begin
              st <= ST_SEND_RAW;
            end
          end else if (wr_kind == WR_SECOND) begin
            err <= 1'b1;
          end
        end
        ST_GOT_FIRST: begin
          if (wr_kind == WR_FIRST) begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end else if (wr_kind == WR_SECOND) begin
            if (pair_ok) begin
              held_q2 <= wr_data;
              st      <= ST_SEND_Q1;
            end else begin
              err <= 1'b1;
              st  <= ST_IDLE;
            end
          end
        end
        ST_SEND_Q1:  if (accept) st <= ST_SEND_Q2;
        ST_SEND_Q2: begin
          if (accept) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        ST_SEND_RAW: if (accept) st <= ST_IDLE;
        default:     st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phycfg_tx_fmt_chk.sv
module phycfg_tx_fmt_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready,
  input logic              done,
  input logic              err
);
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_ready));

  // R4
  drop_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !out_valid);
endmodule

bind phycfg_tx_fmt phycfg_tx_fmt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_data(out_data),
  .out_ready(out_ready), .done(done), .err(err)
);

// File: tb/sim_phycfg_tx_fmt.sv
module sim_phycfg_tx_fmt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        out_valid, out_ready = 1'b0, done, err;
  logic [31:0] out_data;
  int n_chk = 0, n_fail = 0;

  localparam logic [31:0] VEC [6] = '{
    32'h3F95_00E0, 32'hDEAD_BEEF, 32'h0000_00E0,
    32'h1234_00E1, 32'hFFFF_00E0, 32'hA5C3_00E0
  };

  always #4 clk = ~clk;

  phycfg_tx_fmt u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic take(input logic [31:0] exp, input int stall, input string tag);
    chk(out_valid && out_data == exp, tag, out_data, exp);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && out_data == exp, "R3 held while stalled", out_data, exp);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!out_valid && !done && !err, "R1 reset state", {29'd0, out_valid, done, err}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !done && !err, "R1 after reset", {29'd0, out_valid, done, err}, 32'd0);
  endtask

  task automatic run_vec(input logic [31:0] f, input int stall);
    logic [31:0] q1s, q2;
    q1s = {f[31:16], 16'h0000};
    q2  = ~q1s;
    if (f[15:0] == 16'h00E0) begin
      wr(8'h80, f);
      chk(!out_valid, "R3 nothing before second", {31'd0, out_valid}, 32'd0);
      wr(8'h8C, q2);
      take(q1s, stall, "R2 first quadlet cleaned");
      take(q2, stall, "R2 second quadlet");
      chk(done, "R8 done pulse", {31'd0, done}, 32'd1);
      @(negedge clk);
      chk(!done && !out_valid, "R8 done one cycle", {30'd0, done, out_valid}, 32'd0);
    end else begin
      wr(8'h80, f);
      take(f, stall, "R7 raw forwarded");
      chk(!done && !out_valid, "R7 no done for raw", {30'd0, done, out_valid}, 32'd0);
    end
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 6; i++) run_vec(VEC[i], i % 3);
    chk(!err, "R2 no error on good pairs", {31'd0, err}, 32'd0);

    // R10: other offset in idle
    wr(8'h84, 32'h0000_00E0);
    chk(!out_valid && !err, "R10 other offset ignored", {30'd0, out_valid, err}, 32'd0);

    // R10: writes while a quadlet is pending
    wr(8'h80, 32'h5A5A_00E0);
    wr(8'h8C, 32'hA5A5_FFFF);
    wr(8'h80, 32'h1111_1111);
    wr(8'h8C, 32'h2222_2222);
    wr(8'h80, 32'h3333_00E0);
    chk(out_valid && out_data == 32'h5A5A_0000 && !err, "R10 pending write ignored", out_data, 32'h5A5A_0000);
    take(32'h5A5A_0000, 0, "R10 first still sent");
    take(32'hA5A5_FFFF, 0, "R10 second still sent");
    @(negedge clk);
    chk(!out_valid && !err, "R10 no extra quadlet", {30'd0, out_valid, err}, 32'd0);

    // R4: mismatch drops the pair
    wr(8'h80, 32'h1234_00E0);
    wr(8'h8C, 32'hEDCB_FFFE);
    chk(err && !out_valid, "R4 mismatch dropped", {30'd0, err, out_valid}, 32'd2);
    @(negedge clk);
    chk(!out_valid, "R4 nothing sent", {31'd0, out_valid}, 32'd0);

    // R9: error sticks through a good packet
    run_vec(32'h0F0F_00E0, 1);
    chk(err, "R9 err sticky", {31'd0, err}, 32'd1);

    // R5: second without first
    do_reset();
    wr(8'h8C, 32'hFFFF_FFFF);
    chk(err && !out_valid, "R5 orphan second", {30'd0, err, out_valid}, 32'd2);

    // R6: repeated first
    do_reset();
    wr(8'h80, 32'h1111_00E0);
    wr(8'h80, 32'h2222_00E0);
    chk(err && !out_valid, "R6 repeated first", {30'd0, err, out_valid}, 32'd2);
    wr(8'h8C, 32'hDDDD_FFFF);
    @(negedge clk);
    chk(!out_valid, "R6 pair discarded", {31'd0, out_valid}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule